// File: doc/BRIEF.md
# Register-Write Command Stream Decoder

This block takes a byte stream of bulk commands on a valid/ready byte port. It turns register-set commands into writes to the 8-bit-addressed video register file of a display controller. Each command opens with an escape byte (0xAF) and a command code. The register-set code (0x20) carries two more bytes: first the register address, then the value. Any other code, and any byte that arrives where a command should start, is thrown away. The parser then waits for the next escape byte, which is how it regains framing.

The register file keeps a shadow copy and an active copy. A write of 0x00 to address 0xFF locks the video registers. While they are locked, writes reach only the shadow copy. A write of 0xFF to address 0xFF unlocks them and copies the whole shadow set into the active set in one clock edge, so a mode change lands all at once.

The active set is decoded for the timing generator into these outputs:
- colour depth
- two 24-bit frame base addresses
- twelve 16-bit timing fields, stored high byte first
- a pixel clock in 5 kHz units, stored low byte first
- an output state: display on, blanked, or power-down. Power-down can only be left by a full lock/unlock reprogram.

The parser is a four-state machine. IDLE waits for 0xAF and moves to CODE. CODE moves to ADDR on 0x20 and goes back to IDLE on any other byte. ADDR latches the address and moves to DATA. DATA issues the write and returns to IDLE. A state only changes on a cycle where a byte is accepted.

Top module: `regcmd_decoder`

## Requirements
- R1: After reset the following hold. `in_ready` is 1 and `locked` is 0. All register bytes are 0, so every base, timing and clock output is 0. `depth_24` is 0, `display_on` is 1, and `blanked` and `power_down` are 0.
- R2: The sequence 0xAF, 0x20, A, V writes value V to register A. While unlocked, the write reaches the active outputs within three clock cycles of the last byte.
- R3: A write of 0x00 to register 0xFF sets `locked`. Writes made while locked leave every active output unchanged.
- R4: In IDLE, a byte other than 0xAF is dropped, and a later well-formed command is still decoded correctly.
- R5: After 0xAF, a code other than 0x20 returns the parser to IDLE without writing anything. The two bytes that follow are then treated as stray bytes and do not cause a write.
- R6: A write of 0xFF to register 0xFF clears `locked` and copies every shadow register to the active set on a single clock edge. Any other value written to register 0xFF has no effect.
- R7: Timing field k (k = 0..11) takes its high byte from register 1+2k and its low byte from register 2+2k; it appears on `timing[16k+15:16k]`. `pix_clk_5k` takes its high byte from 0x1C and its low byte from 0x1B. `base16` is built from 0x20 (MSB), 0x21 and 0x22 (LSB). `base8` is built from 0x26 (MSB), 0x27 and 0x28 (LSB).
- R8: `depth_24` equals bit 0 of register 0x00 (0 = 16 bpp, 1 = 24 bpp).
- R9: Register 0x1F sets the output state. A value of 0x00 gives `display_on`. A value of 0x07 gives `power_down`. Any other value (for example 0x01) gives `blanked`. Exactly one of the three outputs is high at any time.
- R10: Once in power-down, the block stays there through unlocked writes to 0x1F. Only an unlock commit whose shadow value of 0x1F is not 0x07 leaves power-down.
- R11: A write to an address at or above REG_COUNT (other than 0xFF) changes no register. This includes addresses whose low bits match a real register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Command byte valid |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Byte accepted (always 1) |
| locked | output | 1 | Video registers locked |
| depth_24 | output | 1 | 1 = 24 bpp, 0 = 16 bpp |
| base16 | output | 24 | Active 16 bpp frame base |
| base8 | output | 24 | Active 8 bpp frame base |
| timing | output | 16*NUM_PAIRS | Active timing fields, field k at bits 16k+15:16k |
| pix_clk_5k | output | 16 | Active pixel clock in 5 kHz units |
| display_on | output | 1 | Syncs active |
| blanked | output | 1 | Syncs off, screen blank but powered |
| power_down | output | 1 | Powered down |

## Verification
The bench builds the block with its defaults, REG_COUNT = 48 and NUM_PAIRS = 12. The file therefore covers addresses 0x00 to 0x2F, and the last timing pair sits at 0x17/0x18, so both ends of the timing vector can be checked. Because REG_COUNT is 48, address 0x40 is out of range but its low six bits select register 0x00. This lets the bench detect an address that is truncated instead of range-checked, by watching `depth_24` after a write to 0x40.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
    localparam logic [7:0] ESC_BYTE = 8'hAF;
    localparam logic [7:0] CODE_SET = 8'h20;
    localparam logic [7:0] LOCK_ADDR = 8'hFF;
    localparam logic [7:0] LOCK_VAL = 8'h00;
    localparam logic [7:0] UNLOCK_VAL = 8'hFF;
    localparam logic [7:0] PD_VAL = 8'h07;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CODE,
        S_ADDR,
        S_DATA
    } parse_state_t;
endpackage

// File: rtl/cmd_parser.sv
module cmd_parser
    import regcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       wr_valid,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    parse_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (in_valid) begin
            unique case (state_q)
                S_IDLE: if (in_data == ESC_BYTE) state_d = S_CODE;
                S_CODE: state_d = (in_data == CODE_SET) ? S_ADDR : S_IDLE;
                S_ADDR: state_d = S_DATA;
                S_DATA: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (in_valid && state_q == S_ADDR) wr_addr <= in_data;
            if (in_valid && state_q == S_DATA) begin
                wr_valid <= 1'b1;
                wr_data  <= in_data;
            end
        end
    end

    AST_WR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(state_q == S_DATA && in_valid)); // R2
    AST_STRAY_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && in_valid && in_data != ESC_BYTE) |=> state_q == S_IDLE); // R4
    AST_BAD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CODE && in_valid && in_data != CODE_SET) |=> (state_q == S_IDLE && !wr_valid)); // R5
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
    import regcmd_pkg::*;
#(
    parameter int REG_COUNT = 48
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_valid,
    input  logic [7:0]             wr_addr,
    input  logic [7:0]             wr_data,
    output logic [REG_COUNT*8-1:0] act_flat,
    output logic                   locked,
    output logic                   pd
);
    localparam int IDX_W = $clog2(REG_COUNT);
    localparam int OUTCTL_IDX = 'h1F;

    logic [7:0] shadow_q [REG_COUNT];
    logic [7:0] active_q [REG_COUNT];
    logic       lock_wr, commit, in_range;
    logic [IDX_W-1:0] idx;

    assign lock_wr  = wr_valid && wr_addr == LOCK_ADDR;
    assign commit   = lock_wr && wr_data == UNLOCK_VAL;
    assign in_range = int'(wr_addr) < REG_COUNT;
    assign idx      = wr_addr[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                shadow_q[i] <= '0;
                active_q[i] <= '0;
            end
            locked <= 1'b0;
            pd     <= 1'b0;
        end else if (lock_wr) begin
            if (wr_data == LOCK_VAL) locked <= 1'b1;
            if (commit) begin
                locked <= 1'b0;
                for (int i = 0; i < REG_COUNT; i++) active_q[i] <= shadow_q[i];
                pd <= (shadow_q[OUTCTL_IDX] == PD_VAL);
            end
        end else if (wr_valid && in_range) begin
            shadow_q[idx] <= wr_data;
            if (!locked) begin
                active_q[idx] <= wr_data;
                if (int'(wr_addr) == OUTCTL_IDX && wr_data == PD_VAL) pd <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_flat
        assign act_flat[g*8 +: 8] = active_q[g];
    end

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !commit) |=> $stable(act_flat)); // R3
    AST_PD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pd && !commit) |=> pd); // R10
    AST_COMMIT_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !locked); // R6
endmodule

// File: rtl/active_decode.sv
module active_decode #(
    parameter int REG_COUNT = 48,
    parameter int NUM_PAIRS = 12
) (
    input  logic [REG_COUNT*8-1:0]   act_flat,
    input  logic                     pd,
    output logic                     depth_24,
    output logic [23:0]              base16,
    output logic [23:0]              base8,
    output logic [NUM_PAIRS*16-1:0]  timing,
    output logic [15:0]              pix_clk_5k,
    output logic                     display_on,
    output logic                     blanked,
    output logic                     power_down
);
    localparam int DEPTH_A = 'h00;
    localparam int PCLK_A  = 'h1B;
    localparam int OUTC_A  = 'h1F;
    localparam int B16_A   = 'h20;
    localparam int B8_A    = 'h26;

    assign depth_24   = act_flat[DEPTH_A*8];
    assign base16     = {act_flat[B16_A*8 +: 8], act_flat[(B16_A+1)*8 +: 8], act_flat[(B16_A+2)*8 +: 8]};
    assign base8      = {act_flat[B8_A*8 +: 8], act_flat[(B8_A+1)*8 +: 8], act_flat[(B8_A+2)*8 +: 8]};
    assign pix_clk_5k = {act_flat[(PCLK_A+1)*8 +: 8], act_flat[PCLK_A*8 +: 8]};

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        localparam int HI = 1 + 2*k;
        assign timing[k*16 +: 16] = {act_flat[HI*8 +: 8], act_flat[(HI+1)*8 +: 8]};
    end

    assign power_down = pd;
    assign display_on = !pd && act_flat[OUTC_A*8 +: 8] == 8'h00;
    assign blanked    = !pd && act_flat[OUTC_A*8 +: 8] != 8'h00;

    always_comb begin
        AST_ONE_OUT_STATE: assert ($onehot({display_on, blanked, power_down})); // R9
    end
endmodule

// File: rtl/regcmd_decoder.sv
module regcmd_decoder #(
    parameter int REG_COUNT = 48,
    parameter int NUM_PAIRS = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [7:0]              in_data,
    output logic                    in_ready,
    output logic                    locked,
    output logic                    depth_24,
    output logic [23:0]             base16,
    output logic [23:0]             base8,
    output logic [NUM_PAIRS*16-1:0] timing,
    output logic [15:0]             pix_clk_5k,
    output logic                    display_on,
    output logic                    blanked,
    output logic                    power_down
);
    logic                   wr_valid;
    logic [7:0]             wr_addr, wr_data;
    logic [REG_COUNT*8-1:0] act_flat;
    logic                   pd;

    assign in_ready = 1'b1;

    cmd_parser u_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    shadow_regfile #(.REG_COUNT(REG_COUNT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .act_flat(act_flat), .locked(locked), .pd(pd)
    );

    active_decode #(.REG_COUNT(REG_COUNT), .NUM_PAIRS(NUM_PAIRS)) u_dec (
        .act_flat(act_flat), .pd(pd), .depth_24(depth_24), .base16(base16),
        .base8(base8), .timing(timing), .pix_clk_5k(pix_clk_5k),
        .display_on(display_on), .blanked(blanked), .power_down(power_down)
    );
endmodule

// File: tb/tb_regcmd_decoder.sv
module tb_regcmd_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, locked, depth_24, display_on, blanked, power_down;
    logic [23:0] base16, base8;
    logic [191:0] timing;
    logic [15:0] pix_clk_5k;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    regcmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .locked(locked), .depth_24(depth_24),
        .base16(base16), .base8(base8), .timing(timing), .pix_clk_5k(pix_clk_5k),
        .display_on(display_on), .blanked(blanked), .power_down(power_down)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] v);
        send(8'hAF); send(8'h20); send(a); send(v);
        settle();
    endtask

    task automatic t_reset();
        check("R1 ready", 64'(in_ready), 1);
        check("R1 locked", 64'(locked), 0);
        check("R1 timing", timing[63:0], 0);
        check("R1 base16", 64'(base16), 0);
        check("R1 pclk", 64'(pix_clk_5k), 0);
        check("R1 outstate", {61'd0, display_on, blanked, power_down}, 64'b100);
        check("R1 depth", 64'(depth_24), 0);
    endtask

    task automatic t_write_order();
        wreg(8'h01, 8'hAB); wreg(8'h02, 8'hCD);
        check("R2 R7 timing field0", 64'(timing[15:0]), 64'hABCD);
        wreg(8'h17, 8'h5A); wreg(8'h18, 8'hC3);
        check("R7 timing field11", 64'(timing[191:176]), 64'h5AC3);
        wreg(8'h1B, 8'h34); wreg(8'h1C, 8'h12);
        check("R7 pixel clock", 64'(pix_clk_5k), 64'h1234);
        wreg(8'h20, 8'h01); wreg(8'h21, 8'h02); wreg(8'h22, 8'h03);
        check("R7 base16", 64'(base16), 64'h010203);
        wreg(8'h26, 8'h0A); wreg(8'h27, 8'h0B); wreg(8'h28, 8'h0C);
        check("R7 base8", 64'(base8), 64'h0A0B0C);
    endtask

    task automatic t_depth();
        wreg(8'h00, 8'h01);
        check("R8 depth 24", 64'(depth_24), 1);
        wreg(8'h00, 8'h00);
        check("R8 depth 16", 64'(depth_24), 0);
    endtask

    task automatic t_stray();
        send(8'h20); send(8'h00); send(8'h01); send(8'h12);
        settle();
        check("R4 stray dropped", 64'(depth_24), 0);
        wreg(8'h03, 8'h77);
        check("R4 resync write", 64'(timing[31:24]), 64'h77);
    endtask

    task automatic t_bad_code();
        send(8'hAF); send(8'h21); send(8'h00); send(8'h01);
        settle();
        check("R5 bad code no write", 64'(depth_24), 0);
        wreg(8'h04, 8'h66);
        check("R5 recovers", 64'(timing[23:16]), 64'h66);
    endtask

    task automatic t_lock_commit();
        wreg(8'hFF, 8'h00);
        check("R3 locked", 64'(locked), 1);
        wreg(8'h01, 8'h11); wreg(8'h02, 8'h22);
        check("R3 active held", 64'(timing[15:0]), 64'hABCD);
        wreg(8'hFF, 8'h55);
        check("R6 other lock value ignored", {62'd0, locked, 1'b0} | 64'(timing[15:0] == 16'hABCD), 64'b11);
        send(8'hAF); send(8'h20); send(8'hFF); send(8'hFF);
        repeat (2) @(negedge clk);
        check("R6 commit one edge", 64'(timing[15:0]), 64'h1122);
        check("R6 unlocked", 64'(locked), 0);
        settle();
    endtask

    task automatic t_outctl();
        wreg(8'h1F, 8'h01);
        check("R9 blanked", {61'd0, display_on, blanked, power_down}, 64'b010);
        wreg(8'h1F, 8'h00);
        check("R9 display on", {61'd0, display_on, blanked, power_down}, 64'b100);
        wreg(8'h1F, 8'h07);
        check("R9 power down", {61'd0, display_on, blanked, power_down}, 64'b001);
    endtask

    task automatic t_pd_sticky();
        wreg(8'h1F, 8'h00);
        check("R10 direct write stays pd", 64'(power_down), 1);
        wreg(8'hFF, 8'h00); wreg(8'h1F, 8'h00); wreg(8'hFF, 8'hFF);
        check("R10 reprogram leaves pd", {61'd0, display_on, blanked, power_down}, 64'b100);
    endtask

    task automatic t_out_of_range();
        wreg(8'h40, 8'h01);
        check("R11 alias addr ignored", 64'(depth_24), 0);
        wreg(8'h30, 8'h01);
        check("R11 addr 0x30 ignored", 64'(depth_24), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_order();
        t_depth();
        t_stray();
        t_bad_code();
        t_lock_commit();
        t_outctl();
        t_pd_sticky();
        t_out_of_range();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule